// File: doc/BRIEF.md
# Integer ALU with Signed Condition Flags

A purely combinational integer datapath for a compact two-operand instruction subset. Each operation takes a destination operand and a source operand and produces a result, a write enable for the destination, and new overflow (OF), sign (SF) and zero (ZF) flags. The flags currently held by the surrounding core come back in on `of_i`, `sf_i` and `zf_i`. Operations that leave the flags alone pass these inputs straight through to the flag outputs.

A condition evaluator decodes a condition select against the incoming flags and drives `cond_o`. A sequencer uses this output to resolve conditional jumps. The byte-set operation uses the same output inside the ALU. The width is a parameter of at least 16 bits, and 64 is the default. The shift amount field is as wide as log2 of the width.

Top module: `alu64_flags`

## Requirements
- R1: Operation codes on `op_i` are: 0 negate, 1 add, 2 subtract (dst−src), 3 signed multiply, 4 not, 5 and, 6 or, 7 xor, 8 arithmetic right shift, 9 left shift, 10 logical right shift, 11 compare, 12 byte-set, and 13–15 reserved. Negate, add and subtract write the wrapped two's-complement result and set OF exactly when the true signed result lies outside the representable range. Negating the most negative value returns that value with OF=1.
- R2: Subtract corners: MAX−(−1) gives MIN with OF=1, SF=1, ZF=0. MIN−1 gives MAX with OF=1, SF=0, ZF=0. MAX−1 and MIN−(−1) give OF=0.
- R3: Signed multiply writes the low half of the double-width signed product. It sets OF when the full product differs from the sign extension of that low half.
- R4: Every operation that computes flags sets SF to the result's top bit and sets ZF when the result is all zeros.
- R5: And, or and xor clear OF. Not writes the bitwise complement and passes all three flags through unchanged.
- R6: Shifts use only the low log2(width) bits of `src_i` as the amount. For a nonzero amount, OF is defined only at amount 1: it is 0 for the arithmetic right shift, dst[top]^dst[top−1] for the left shift, and dst[top] for the logical right shift. For larger amounts OF passes through.
- R7: A shift whose amount field is zero writes `dst_i` unchanged and passes all three flags through.
- R8: Compare sets the flags exactly as subtract would, deasserts `wr_en_o`, and drives `res_o` with `dst_i`.
- R9: Condition codes on `cc_i` are: 0 equal (ZF), 1 not-equal (!ZF), 2 greater (!ZF and SF==OF), 3 less (SF!=OF), 4 greater-or-equal (SF==OF), 5 less-or-equal (SF!=OF or ZF). Codes 6 and 7 evaluate false. The evaluation uses the incoming flags.
- R10: Byte-set writes `dst_i` with bits 7:0 replaced by 8'h01 when the selected condition holds and 8'h00 otherwise. The flags pass through.
- R11: Reserved codes deassert `wr_en_o`, drive `res_o` with `dst_i`, and pass the flags through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select |
| cc_i | input | 3 | Condition select |
| dst_i | input | WIDTH | Destination operand (first operand) |
| src_i | input | WIDTH | Source operand (second operand, shift amount) |
| of_i | input | 1 | Current overflow flag |
| sf_i | input | 1 | Current sign flag |
| zf_i | input | 1 | Current zero flag |
| res_o | output | WIDTH | Result value |
| wr_en_o | output | 1 | Destination write enable |
| of_o | output | 1 | Next overflow flag |
| sf_o | output | 1 | Next sign flag |
| zf_o | output | 1 | Next zero flag |
| cond_o | output | 1 | Selected condition holds |

## Verification
The bench builds the block at its default width of 64. At that width the stated signed extremes (MAX, MIN, −1) can be written directly as literals. The shift amount field is 6 bits wide, so an amount of 64 lands on the zero-amount case and can be checked as a pass-through. The reference model finds overflow by computing each result in 128-bit signed arithmetic and comparing it with the sign-extended truncated result. This covers the negate, add, subtract and multiply overflow cases without reusing the carry rules of the design.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

   typedef enum logic [3:0] {
      OP_NEG  = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_IMUL = 4'd3,
      OP_NOT  = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_SAR  = 4'd8,
      OP_SHL  = 4'd9,
      OP_SHR  = 4'd10,
      OP_CMP  = 4'd11,
      OP_SETB = 4'd12
   } alu_op_e;

   typedef enum logic [2:0] {
      CC_EQ = 3'd0,
      CC_NE = 3'd1,
      CC_GT = 3'd2,
      CC_LT = 3'd3,
      CC_GE = 3'd4,
      CC_LE = 3'd5
   } alu_cc_e;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
   } alu_flags_t;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub
   import alu64_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic             negate, subtract;
   logic [WIDTH-1:0] lhs, rhs, rhs_eff;

   always_comb begin
      negate   = (op == OP_NEG);
      subtract = negate || (op == OP_SUB) || (op == OP_CMP);
      lhs      = negate ? '0 : a;
      rhs      = negate ? a : b;
      rhs_eff  = subtract ? ~rhs : rhs;
      sum      = lhs + rhs_eff + {{(WIDTH-1){1'b0}}, subtract};
      // overflow when operands (after effective sign) agree but the sum disagrees
      ovf      = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
   end
endmodule

// File: rtl/alu64_mul.sv
module alu64_mul #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] prod_lo,
   output logic             ovf
);
   localparam int PW = 2 * WIDTH;

   logic signed [PW-1:0] full;

   always_comb begin
      full    = PW'($signed(a)) * PW'($signed(b));
      prod_lo = full[WIDTH-1:0];
      ovf     = (full[PW-1:WIDTH] != {WIDTH{full[WIDTH-1]}});
   end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
   import alu64_pkg::*;
#(
   parameter int WIDTH = 64,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [AMT_W-1:0] amt,
   input  logic             ovf_in,
   output logic [WIDTH-1:0] res,
   output logic             ovf,
   output logic             amt_zero
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      amt_zero = (amt == '0);
      unique case (op)
         OP_SAR:  res = WIDTH'($signed(a) >>> amt);
         OP_SHL:  res = a << amt;
         default: res = a >> amt;
      endcase
      if (amt == AMT_W'(1)) begin
         unique case (op)
            OP_SAR:  ovf = 1'b0;
            OP_SHL:  ovf = a[MSB] ^ a[MSB-1];
            default: ovf = a[MSB];
         endcase
      end else begin
         ovf = ovf_in;
      end
   end
endmodule

// File: rtl/alu64_cond.sv
module alu64_cond
   import alu64_pkg::*;
(
   input  alu_flags_t flags,
   input  logic [2:0] cc,
   output logic       hit
);
   logic lt;

   always_comb begin
      lt = flags.sgn ^ flags.ovf;
      unique case (cc)
         CC_EQ:   hit = flags.zro;
         CC_NE:   hit = !flags.zro;
         CC_GT:   hit = !flags.zro && !lt;
         CC_LT:   hit = lt;
         CC_GE:   hit = !lt;
         CC_LE:   hit = lt || flags.zro;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu64_flags.sv
module alu64_flags
   import alu64_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [3:0]       op_i,
   input  logic [2:0]       cc_i,
   input  logic [WIDTH-1:0] dst_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic             of_i,
   input  logic             sf_i,
   input  logic             zf_i,
   output logic [WIDTH-1:0] res_o,
   output logic             wr_en_o,
   output logic             of_o,
   output logic             sf_o,
   output logic             zf_o,
   output logic             cond_o
);
   localparam int AMT_W = $clog2(WIDTH);
   localparam int MSB   = WIDTH - 1;

   generate
      if (WIDTH < 16) begin : g_width_bad
         $error("alu64_flags: WIDTH must be at least 16");
      end
      if ((WIDTH & (WIDTH - 1)) != 0) begin : g_pow2_bad
         $error("alu64_flags: WIDTH must be a power of two");
      end
   endgenerate

   alu_flags_t       fl_in, fl_out;
   logic [WIDTH-1:0] as_res, mul_res, sh_res, lg_res;
   logic             as_ovf, mul_ovf, sh_ovf, sh_zero;

   assign fl_in = '{ovf: of_i, sgn: sf_i, zro: zf_i};

   alu64_addsub #(.WIDTH(WIDTH)) u_addsub (
      .op(op_i), .a(dst_i), .b(src_i), .sum(as_res), .ovf(as_ovf)
   );

   alu64_mul #(.WIDTH(WIDTH)) u_mul (
      .a(dst_i), .b(src_i), .prod_lo(mul_res), .ovf(mul_ovf)
   );

   alu64_shift #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shift (
      .op(op_i), .a(dst_i), .amt(src_i[AMT_W-1:0]), .ovf_in(of_i),
      .res(sh_res), .ovf(sh_ovf), .amt_zero(sh_zero)
   );

   alu64_cond u_cond (
      .flags(fl_in), .cc(cc_i), .hit(cond_o)
   );

   always_comb begin
      unique case (op_i)
         OP_AND:  lg_res = dst_i & src_i;
         OP_OR:   lg_res = dst_i | src_i;
         default: lg_res = dst_i ^ src_i;
      endcase
   end

   always_comb begin
      res_o   = dst_i;
      wr_en_o = 1'b1;
      fl_out  = fl_in;
      unique case (op_i)
         OP_NEG, OP_ADD, OP_SUB: begin
            res_o  = as_res;
            fl_out = '{ovf: as_ovf, sgn: as_res[MSB], zro: (as_res == '0)};
         end
         OP_CMP: begin
            wr_en_o = 1'b0;
            fl_out  = '{ovf: as_ovf, sgn: as_res[MSB], zro: (as_res == '0)};
         end
         OP_IMUL: begin
            res_o  = mul_res;
            fl_out = '{ovf: mul_ovf, sgn: mul_res[MSB], zro: (mul_res == '0)};
         end
         OP_NOT: res_o = ~dst_i;
         OP_AND, OP_OR, OP_XOR: begin
            res_o  = lg_res;
            fl_out = '{ovf: 1'b0, sgn: lg_res[MSB], zro: (lg_res == '0)};
         end
         OP_SAR, OP_SHL, OP_SHR: begin
            if (!sh_zero) begin
               res_o  = sh_res;
               fl_out = '{ovf: sh_ovf, sgn: sh_res[MSB], zro: (sh_res == '0)};
            end
         end
         OP_SETB: res_o = {dst_i[WIDTH-1:8], 7'b0, cond_o};
         default: wr_en_o = 1'b0;
      endcase
   end

   assign of_o = fl_out.ovf;
   assign sf_o = fl_out.sgn;
   assign zf_o = fl_out.zro;

endmodule

// File: rtl/alu64_flags_chk.sv
module alu64_flags_chk
   import alu64_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input logic [3:0]       op_i,
   input logic [2:0]       cc_i,
   input logic [WIDTH-1:0] dst_i,
   input logic [WIDTH-1:0] src_i,
   input logic             of_i,
   input logic             sf_i,
   input logic             zf_i,
   input logic [WIDTH-1:0] res_o,
   input logic             wr_en_o,
   input logic             of_o,
   input logic             sf_o,
   input logic             zf_o,
   input logic             cond_o
);
   localparam int MSB   = WIDTH - 1;
   localparam int AMT_W = $clog2(WIDTH);

   always_comb begin
      // R1
      add_ovf_chk: assert (!((op_i == OP_ADD) && (dst_i[MSB] == src_i[MSB]) &&
                             (res_o[MSB] != dst_i[MSB])) || of_o);
      // R4
      zero_flag_chk: assert (!((op_i inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR}) &&
                               (res_o == '0)) || zf_o);
      // R5
      not_flags_chk: assert (!(op_i == OP_NOT) ||
                             ({of_o, sf_o, zf_o} == {of_i, sf_i, zf_i}));
      // R7
      zero_shift_chk: assert (!((op_i inside {OP_SAR, OP_SHL, OP_SHR}) &&
                                (src_i[AMT_W-1:0] == '0)) ||
                              ((res_o == dst_i) && ({of_o, sf_o, zf_o} == {of_i, sf_i, zf_i})));
      // R8
      cmp_nowrite_chk: assert (!(op_i == OP_CMP) || !wr_en_o);
      // R9
      cond_eq_chk: assert (!(cc_i == CC_EQ) || (cond_o == zf_i));
      // R9
      cond_lt_chk: assert (!(cc_i == CC_LT) || (cond_o == (sf_i != of_i)));
      // R10
      setb_upper_chk: assert (!(op_i == OP_SETB) ||
                              ((res_o[WIDTH-1:8] == dst_i[WIDTH-1:8]) &&
                               (res_o[7:0] == {7'b0, cond_o})));
      // R11
      rsvd_nowrite_chk: assert (!(op_i > OP_SETB) || (!wr_en_o && (res_o == dst_i)));
   end
endmodule

bind alu64_flags alu64_flags_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i(op_i), .cc_i(cc_i), .dst_i(dst_i), .src_i(src_i),
   .of_i(of_i), .sf_i(sf_i), .zf_i(zf_i),
   .res_o(res_o), .wr_en_o(wr_en_o), .of_o(of_o), .sf_o(sf_o),
   .zf_o(zf_o), .cond_o(cond_o)
);

// File: tb/alu64_flags_tb.sv
module alu64_flags_tb;
   localparam int W = 64;
   localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
   localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 24;

   // op, dst, src, flags-in {of,sf,zf}
   localparam logic [134:0] VEC [NV] = '{
      {4'd1,  64'd5,                  64'd7,                  3'b000},
      {4'd1,  MAXV,                   64'd1,                  3'b000},
      {4'd1,  MINV,                   NEG1,                   3'b000},
      {4'd1,  NEG1,                   64'd1,                  3'b111},
      {4'd2,  64'd3,                  64'd10,                 3'b000},
      {4'd0,  64'd0,                  64'd0,                  3'b010},
      {4'd0,  64'd9,                  64'd0,                  3'b000},
      {4'd3,  64'hFFFF_FFFF,          64'h1_0000_0001,        3'b000},
      {4'd3,  NEG1,                   NEG1,                   3'b100},
      {4'd3,  MINV,                   NEG1,                   3'b000},
      {4'd4,  64'h00FF_00FF_00FF_00FF,64'd0,                  3'b101},
      {4'd5,  64'hF0F0_F0F0_F0F0_F0F0,64'h0F0F_0F0F_0F0F_0F0F,3'b100},
      {4'd6,  MINV,                   64'd1,                  3'b101},
      {4'd7,  64'h1234_5678_9ABC_DEF0,64'h1234_5678_9ABC_DEF0,3'b100},
      {4'd8,  MINV,                   64'd1,                  3'b100},
      {4'd8,  MINV,                   64'd63,                 3'b100},
      {4'd9,  64'h4000_0000_0000_0000,64'd1,                  3'b000},
      {4'd9,  64'hC000_0000_0000_0001,64'd1,                  3'b100},
      {4'd9,  64'd1,                  64'd65,                 3'b000},
      {4'd10, MINV,                   64'd1,                  3'b000},
      {4'd10, NEG1,                   64'd4,                  3'b100},
      {4'd11, 64'd4,                  64'd9,                  3'b000},
      {4'd11, MINV,                   64'd1,                  3'b000},
      {4'd12, 64'hAAAA_AAAA_AAAA_AAAA,64'd0,                  3'b011}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0]   op_i = '0;
   logic [2:0]   cc_i = '0;
   logic [W-1:0] dst_i = '0, src_i = '0;
   logic of_i = 1'b0, sf_i = 1'b0, zf_i = 1'b0;
   logic [W-1:0] res_o;
   logic wr_en_o, of_o, sf_o, zf_o, cond_o;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   alu64_flags #(.WIDTH(W)) u_dut (
      .op_i(op_i), .cc_i(cc_i), .dst_i(dst_i), .src_i(src_i),
      .of_i(of_i), .sf_i(sf_i), .zf_i(zf_i),
      .res_o(res_o), .wr_en_o(wr_en_o), .of_o(of_o), .sf_o(sf_o),
      .zf_o(zf_o), .cond_o(cond_o)
   );

   function automatic logic ref_cond(input logic [2:0] cc, input logic o, input logic s, input logic z);
      case (cc)
         3'd0: return z;
         3'd1: return !z;
         3'd2: return !z && (s == o);
         3'd3: return s != o;
         3'd4: return s == o;
         3'd5: return (s != o) || z;
         default: return 1'b0;
      endcase
   endfunction

   // returns {res, we, of, sf, zf}
   function automatic logic [67:0] ref_model(input logic [3:0] op, input logic [2:0] cc,
                                             input logic [63:0] d, input logic [63:0] s,
                                             input logic [2:0] fi);
      logic signed [127:0] t;
      logic [63:0] r;
      logic we;
      logic [2:0] fo;
      logic [5:0] amt;
      r = d; we = 1'b1; fo = fi; amt = s[5:0];
      case (op)
         4'd0, 4'd1, 4'd2, 4'd3, 4'd11: begin
            if (op == 4'd0)      t = -$signed({{64{d[63]}}, d});
            else if (op == 4'd1) t = $signed({{64{d[63]}}, d}) + $signed({{64{s[63]}}, s});
            else if (op == 4'd3) t = $signed({{64{d[63]}}, d}) * $signed({{64{s[63]}}, s});
            else                 t = $signed({{64{d[63]}}, d}) - $signed({{64{s[63]}}, s});
            fo = {t != $signed({{64{t[63]}}, t[63:0]}), t[63], t[63:0] == 64'd0};
            if (op == 4'd11) we = 1'b0; else r = t[63:0];
         end
         4'd4: r = ~d;
         4'd5, 4'd6, 4'd7: begin
            r = (op == 4'd5) ? (d & s) : (op == 4'd6) ? (d | s) : (d ^ s);
            fo = {1'b0, r[63], r == 64'd0};
         end
         4'd8, 4'd9, 4'd10: begin
            if (amt != 6'd0) begin
               if (op == 4'd8)      r = 64'($signed(d) >>> amt);
               else if (op == 4'd9) r = d << amt;
               else                 r = d >> amt;
               fo[1] = r[63];
               fo[0] = (r == 64'd0);
               if (amt == 6'd1)
                  fo[2] = (op == 4'd8) ? 1'b0 : (op == 4'd9) ? (d[63] ^ d[62]) : d[63];
            end
         end
         4'd12: r = {d[63:8], 7'd0, ref_cond(cc, fi[2], fi[1], fi[0])};
         default: we = 1'b0;
      endcase
      return {r, we, fo};
   endfunction

   task automatic apply(input logic [3:0] op, input logic [2:0] cc, input logic [63:0] d,
                        input logic [63:0] s, input logic [2:0] fi);
      @(negedge clk);
      op_i = op; cc_i = cc; dst_i = d; src_i = s;
      {of_i, sf_i, zf_i} = fi;
      #5;
   endtask

   task automatic check(input string tag, input logic [68:0] act, input logic [68:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R4 idle state after reset: negate of zero
      apply(4'd0, 3'd0, 64'd0, 64'd0, 3'b000);
      check("R4 idle", {res_o, wr_en_o, of_o, sf_o, zf_o, cond_o},
            {64'd0, 1'b1, 3'b001, 1'b0});

      // R1 R3 R4 R5 R6 R8 R10 table walk against the reference model
      for (int i = 0; i < NV; i++) begin
         logic [3:0] op; logic [63:0] d, s; logic [2:0] f; logic [2:0] cc;
         {op, d, s, f} = VEC[i];
         cc = 3'(i % 6);
         apply(op, cc, d, s, f);
         check($sformatf("R1 R3 R5 R6 R8 R10 vec%0d", i),
               {res_o, wr_en_o, of_o, sf_o, zf_o, cond_o},
               {ref_model(op, cc, d, s, f), ref_cond(cc, f[2], f[1], f[0])});
      end

      // R2 stated subtract corners
      apply(4'd2, 3'd0, MAXV, NEG1, 3'b000);
      check("R2 max-(-1)", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {MINV, 1'b1, 3'b110, 1'b0});
      apply(4'd2, 3'd0, MINV, 64'd1, 3'b000);
      check("R2 min-1", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {MAXV, 1'b1, 3'b100, 1'b0});
      apply(4'd2, 3'd0, MAXV, 64'd1, 3'b111);
      check("R2 max-1", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'h7FFF_FFFF_FFFF_FFFE, 1'b1, 3'b000, 1'b0});
      apply(4'd2, 3'd0, MINV, NEG1, 3'b000);
      check("R2 min-(-1)", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'h8000_0000_0000_0001, 1'b1, 3'b010, 1'b0});

      // R1 negate most negative
      apply(4'd0, 3'd0, MINV, 64'd0, 3'b000);
      check("R1 neg min", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {MINV, 1'b1, 3'b110, 1'b0});

      // R3 multiply
      apply(4'd3, 3'd0, 64'd2, 64'd3, 3'b111);
      check("R3 2*3", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {64'd6, 1'b1, 3'b000, 1'b0});
      apply(4'd3, 3'd0, MAXV, 64'd2, 3'b000);
      check("R3 max*2", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 3'b110, 1'b0});

      // R8 compare equal operands: flags only, no write, dst on res
      apply(4'd11, 3'd0, 64'd5, 64'd5, 3'b010);
      check("R8 cmp", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {64'd5, 1'b0, 3'b001, 1'b0});

      // R10 byte-set true and false
      apply(4'd12, 3'd0, 64'h1122_3344_5566_7788, 64'd0, 3'b001);
      check("R10 setb true", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'h1122_3344_5566_7701, 1'b1, 3'b001, 1'b0});
      apply(4'd12, 3'd1, 64'h1122_3344_5566_77FF, 64'd0, 3'b001);
      check("R10 setb false", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'h1122_3344_5566_7700, 1'b1, 3'b001, 1'b0});

      // R7 amount 64 masks to zero: pass-through
      apply(4'd9, 3'd0, 64'hDEAD_BEEF_0000_0001, 64'd64, 3'b101);
      check("R7 zero shift", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'hDEAD_BEEF_0000_0001, 1'b1, 3'b101, 1'b0});

      // R6 logical right by 1 of negative value sets OF
      apply(4'd10, 3'd0, MINV, 64'd1, 3'b000);
      check("R6 shr1", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
            {64'h4000_0000_0000_0000, 1'b1, 3'b100, 1'b0});

      // R5 not passes flags
      apply(4'd4, 3'd0, 64'd0, 64'd0, 3'b110);
      check("R5 not", {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0}, {NEG1, 1'b1, 3'b110, 1'b0});

      // R11 reserved codes
      for (int k = 13; k < 16; k++) begin
         apply(4'(k), 3'd0, 64'h55, 64'h1, 3'b011);
         check($sformatf("R11 op%0d", k), {res_o, wr_en_o, of_o, sf_o, zf_o, 1'b0},
               {64'h55, 1'b0, 3'b011, 1'b0});
      end

      // R9 every condition code against every flag combination
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 8; f++) begin
            apply(4'd13, 3'(c), 64'd0, 64'd0, 3'(f));
            check($sformatf("R9 cc%0d fl%0d", c, f), {68'd0, cond_o},
                  {68'd0, ref_cond(3'(c), f[2], f[1], f[0])});
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule